// File: doc/BRIEF.md
# Parity Lane Masked-Write Enable Generator

This block produces the write enables for a memory word made of byte lanes and a parity lane, with one parity bit for each byte. The data bytes are written whole: each byte is written or left alone according to its own select strobe. The parity lane is written bit by bit. When a row cycle opens, the block takes a bit mask from the parity data pins. Every write strobe issued before that row cycle closes then uses this mask, so a page-mode burst can update chosen parity bits and leave the others untouched.

The enables come out in three forms, each one clock after the inputs are sampled. There is one enable per byte lane and one per parity bit. There is also a flat vector with one enable per word bit, laid out so it can drive the bit enables of a memory directly. A parameter removes the parity lane, which gives a data-only word whose parity enables never assert.

Top module: `pwm_parity_wpb`

## Requirements
- R1: In the first cycle that `row_act_i` is high after being low, the block captures `par_pins_i` as the parity mask. That cycle's own write uses this captured mask.
- R2: When the parity lane is written, `par_we_o[i]` is 1 exactly where mask bit i is 1. A mask bit of 0 keeps parity bit i unwritten.
- R3: Within one row cycle, every write uses the mask captured at the start of that cycle. Changes on `par_pins_i` while `row_act_i` stays high have no effect.
- R4: `byte_we_o[i]` follows `byte_sel_i[i]` for a write. Byte lanes have no bit masking.
- R5: A lane is enabled only when its own select and `wr_en_i` are both 1 while `row_act_i` is 1. Without `wr_en_i`, all enables are 0.
- R6: The parity lane has its own select, `par_sel_i`. Byte selects never enable parity bits, and `par_sel_i` never enables a byte.
- R7: `bit_we_o` has lane i at positions 9i to 9i+7, driven by `byte_we_o[i]`, and parity bit i at position 9i+8 (8, 17, 26 and 35 by default), driven by `par_we_o[i]`.
- R8: When `row_act_i` is low, every enable is 0. A mask from an earlier row cycle is never applied in a later one.
- R9: With `PAR_EN` = 0, `par_we_o` and the parity positions of `bit_we_o` stay 0, while byte enables work as in R4.
- R10: All outputs are registered. They are 0 during reset and in the first cycle after it, and each reflects the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_act_i | input | 1 | Row cycle active (level, high while the row is open) |
| wr_en_i | input | 1 | Shared write enable |
| byte_sel_i | input | NUM_BYTES | Per-byte column select strobes |
| par_sel_i | input | 1 | Parity lane column select strobe |
| par_pins_i | input | NUM_BYTES | Parity data pins, mask source at row start |
| byte_we_o | output | NUM_BYTES | Registered byte lane write enables |
| par_we_o | output | NUM_BYTES | Registered parity bit write enables |
| bit_we_o | output | NUM_BYTES*(BYTE_W+1) | Registered per-bit enables of the whole word |

## Verification
The assertions rely on `row_act_i` being a level held by the controller, so that a rise marks a row start and a fall marks a row end. They also assume that enables produced while the row is closed are never expected. The bench drives all inputs on the falling clock edge and holds each value for whole cycles. It opens and closes rows only through `row_act_i` and issues write strobes only as full-cycle pulses. It checks an extra instance built without the parity lane using the same stimulus. A register-file model in the bench applies `bit_we_o` so that parity preservation can be seen at the word level.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Position of lane bit b (b == byte width means the parity bit) in the word.
  function automatic int unsigned lane_bit_pos(input int unsigned lane,
                                               input int unsigned b,
                                               input int unsigned byte_w);
    return lane * (byte_w + 1) + b;
  endfunction

endpackage

// File: rtl/pwm_mask_latch.sv
module pwm_mask_latch #(
  parameter int unsigned MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_act_i,
  input  logic [MASK_W-1:0] pins_i,
  output logic [MASK_W-1:0] mask_eff_o
);

  logic              row_q;
  logic              row_start;
  logic [MASK_W-1:0] mask_q;

  assign row_start  = row_act_i & ~row_q;
  // The write in the row-start cycle already sees the value being captured.
  assign mask_eff_o = row_start ? pins_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      row_q <= row_act_i;
      if (row_start)
        mask_q <= pins_i;
      else if (!row_act_i)
        mask_q <= '0;
    end
  end

  // R1: the mask held after a row start equals the pins at that start
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    (row_act_i && !row_q) |=> (mask_q == $past(pins_i)));

  // R3: the mask does not move while the row stays open
  a_r3_mask_held: assert property (@(posedge clk) disable iff (rst)
    (row_act_i && row_q) |=> $stable(mask_q));

  // R8: closing a row leaves no mask behind
  a_r8_mask_cleared: assert property (@(posedge clk) disable iff (rst)
    !row_act_i |=> (mask_q == '0));

endmodule

// File: rtl/pwm_lane_enables.sv
module pwm_lane_enables #(
  parameter int unsigned NUM_BYTES = 4,
  parameter bit          PAR_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 row_act_i,
  input  logic                 wr_en_i,
  input  logic [NUM_BYTES-1:0] byte_sel_i,
  input  logic                 par_sel_i,
  input  logic [NUM_BYTES-1:0] mask_i,
  output logic [NUM_BYTES-1:0] byte_we_o,
  output logic [NUM_BYTES-1:0] par_we_o
);

  logic wr_ok;
  assign wr_ok = row_act_i & wr_en_i;

  always_ff @(posedge clk) begin
    if (rst) byte_we_o <= '0;
    else     byte_we_o <= wr_ok ? byte_sel_i : '0;
  end

  generate
    if (PAR_EN) begin : g_par
      always_ff @(posedge clk) begin
        if (rst) par_we_o <= '0;
        else     par_we_o <= (wr_ok && par_sel_i) ? mask_i : '0;
      end
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{par_sel_i, mask_i};
      always_ff @(posedge clk) par_we_o <= '0;
    end
  endgenerate

  // R5: a byte enable needs its select and the write enable in an open row
  a_r5_byte_gated: assert property (@(posedge clk) disable iff (rst)
    (byte_we_o & ~$past(byte_sel_i & {NUM_BYTES{wr_en_i & row_act_i}})) == '0);

  // R6: parity enables need the parity select, never a byte select alone
  a_r6_par_own_select: assert property (@(posedge clk) disable iff (rst)
    (par_we_o != '0) |-> $past(par_sel_i && wr_en_i && row_act_i));

  // R2: a parity enable never appears where the mask holds a zero
  a_r2_mask_respected: assert property (@(posedge clk) disable iff (rst)
    (par_we_o & ~$past(mask_i)) == '0);

endmodule

// File: rtl/pwm_bit_expand.sv
module pwm_bit_expand #(
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned WORD_W   = NUM_BYTES * (BYTE_W + 1)
) (
  input  logic [NUM_BYTES-1:0] byte_we_i,
  input  logic [NUM_BYTES-1:0] par_we_i,
  output logic [WORD_W-1:0]    bit_we_o
);
  import pwm_pkg::*;

  generate
    for (genvar l = 0; l < NUM_BYTES; l++) begin : g_lane
      for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign bit_we_o[lane_bit_pos(l, b, BYTE_W)] = byte_we_i[l];
      end
      assign bit_we_o[lane_bit_pos(l, BYTE_W, BYTE_W)] = par_we_i[l];
    end
  endgenerate

endmodule

// File: rtl/pwm_parity_wpb.sv
module pwm_parity_wpb #(
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned BYTE_W    = 8,
  parameter bit          PAR_EN    = 1'b1,
  localparam int unsigned WORD_W   = NUM_BYTES * (BYTE_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 row_act_i,
  input  logic                 wr_en_i,
  input  logic [NUM_BYTES-1:0] byte_sel_i,
  input  logic                 par_sel_i,
  input  logic [NUM_BYTES-1:0] par_pins_i,
  output logic [NUM_BYTES-1:0] byte_we_o,
  output logic [NUM_BYTES-1:0] par_we_o,
  output logic [WORD_W-1:0]    bit_we_o
);

  logic [NUM_BYTES-1:0] mask_eff;

  pwm_mask_latch #(.MASK_W(NUM_BYTES)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .row_act_i  (row_act_i),
    .pins_i     (par_pins_i),
    .mask_eff_o (mask_eff)
  );

  pwm_lane_enables #(.NUM_BYTES(NUM_BYTES), .PAR_EN(PAR_EN)) u_lanes (
    .clk        (clk),
    .rst        (rst),
    .row_act_i  (row_act_i),
    .wr_en_i    (wr_en_i),
    .byte_sel_i (byte_sel_i),
    .par_sel_i  (par_sel_i),
    .mask_i     (mask_eff),
    .byte_we_o  (byte_we_o),
    .par_we_o   (par_we_o)
  );

  pwm_bit_expand #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_expand (
    .byte_we_i (byte_we_o),
    .par_we_i  (par_we_o),
    .bit_we_o  (bit_we_o)
  );

  // R8: a closed row produces no enables in the following cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !row_act_i |=> (bit_we_o == '0));

  // R10: enables are clear in the cycle after reset
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (byte_we_o == '0 && par_we_o == '0));

endmodule

// File: tb/pwm_parity_wpb_tb.sv
module pwm_parity_wpb_tb_top;

  localparam int NB = 4;
  localparam int BW = 8;
  localparam int WW = NB * (BW + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          row_act, wr_en, par_sel;
  logic [NB-1:0] byte_sel, par_pins;
  logic [NB-1:0] byte_we, par_we, byte_we32, par_we32;
  logic [WW-1:0] bit_we, bit_we32;
  logic [WW-1:0] mem_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_parity_wpb #(.NUM_BYTES(NB), .BYTE_W(BW), .PAR_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .row_act_i(row_act), .wr_en_i(wr_en),
    .byte_sel_i(byte_sel), .par_sel_i(par_sel), .par_pins_i(par_pins),
    .byte_we_o(byte_we), .par_we_o(par_we), .bit_we_o(bit_we));

  pwm_parity_wpb #(.NUM_BYTES(NB), .BYTE_W(BW), .PAR_EN(1'b0)) dut32_i (
    .clk(clk), .rst(rst), .row_act_i(row_act), .wr_en_i(wr_en),
    .byte_sel_i(byte_sel), .par_sel_i(par_sel), .par_pins_i(par_pins),
    .byte_we_o(byte_we32), .par_we_o(par_we32), .bit_we_o(bit_we32));

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] expand(input logic [NB-1:0] bw, input logic [NB-1:0] pw);
    logic [WW-1:0] v = '0;
    for (int l = 0; l < NB; l++) begin
      for (int b = 0; b < BW; b++) v[l*(BW+1)+b] = bw[l];
      v[l*(BW+1)+BW] = pw[l];
    end
    return v;
  endfunction

  // Apply inputs at a falling edge, let one rising edge register them,
  // return at the next falling edge for sampling.
  task automatic cyc(input logic row, input logic we, input logic [NB-1:0] bs,
                     input logic ps, input logic [NB-1:0] pins);
    row_act = row; wr_en = we; byte_sel = bs; par_sel = ps; par_pins = pins;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(0, 0, '0, 0, '0);
    cyc(1, 1, 4'hF, 1, 4'hF);
    chk("R10 reset byte", {32'd0, byte_we}, '0);
    chk("R10 reset par", {32'd0, par_we}, '0);
    rst = 1'b0;
    cyc(0, 0, '0, 0, '0);
    chk("R10 first cycle after reset", bit_we, '0);
  endtask

  task automatic t_first_write;
    cyc(1, 1, 4'b0101, 1, 4'b1010);
    chk("R1 mask used in start cycle", {32'd0, par_we}, {32'd0, 4'b1010});
    chk("R4 byte follows select", {32'd0, byte_we}, {32'd0, 4'b0101});
    chk("R7 bit layout", bit_we, expand(4'b0101, 4'b1010));
    chk("R9 variant parity quiet", {32'd0, par_we32}, '0);
    chk("R9 variant bytes", bit_we32, expand(4'b0101, 4'b0000));
  endtask

  task automatic t_burst;
    cyc(1, 1, 4'b1111, 1, 4'b0101);
    chk("R3 pins ignored mid row", {32'd0, par_we}, {32'd0, 4'b1010});
    chk("R2 zero mask bits kept", bit_we, expand(4'b1111, 4'b1010));
    cyc(1, 0, 4'b1111, 1, 4'b1111);
    chk("R5 no write enable", bit_we, '0);
    cyc(1, 1, 4'b0011, 0, 4'b1111);
    chk("R6 byte selects only", bit_we, expand(4'b0011, 4'b0000));
    cyc(1, 1, 4'b0000, 1, 4'b0000);
    chk("R6 parity select only", bit_we, expand(4'b0000, 4'b1010));
  endtask

  task automatic t_row_end;
    cyc(0, 1, 4'b1111, 1, 4'b1111);
    chk("R8 closed row quiet", bit_we, '0);
    cyc(1, 1, 4'b1000, 1, 4'b0000);
    chk("R8 no stale mask", bit_we, expand(4'b1000, 4'b0000));
    cyc(1, 1, 4'b0000, 1, 4'b1111);
    chk("R3 zero mask held", {32'd0, par_we}, '0);
    cyc(0, 0, '0, 0, '0);
    cyc(1, 1, 4'b0000, 1, 4'b1111);
    chk("R1 full mask", {32'd0, par_we}, {32'd0, 4'b1111});
    cyc(0, 0, '0, 0, '0);
  endtask

  // Register-file model: one word written through bit_we.
  task automatic t_model;
    logic [WW-1:0] wd;
    logic [WW-1:0] exp;
    mem_word = '0;
    wd = {WW{1'b1}};
    cyc(1, 1, 4'b0110, 1, 4'b0001);
    mem_word = (mem_word & ~bit_we) | (wd & bit_we);
    exp = '0;
    for (int b = 9; b < 17; b++) exp[b] = 1'b1;
    for (int b = 18; b < 26; b++) exp[b] = 1'b1;
    exp[8] = 1'b1;
    chk("R2 model parity bits kept", mem_word, exp);
    cyc(0, 0, '0, 0, '0);
  endtask

  initial begin
    row_act = 0; wr_en = 0; byte_sel = '0; par_sel = 0; par_pins = '0; rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_write();
    t_burst();
    t_row_end();
    t_model();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule